// File: doc/BRIEF.md
# Interrupt Trigger Detection Unit

This block turns 64 raw interrupt lines into clean per-line pending signals for the interrupt routing logic after it. Each line first passes through a two-flop synchronizer. Its trigger condition is then judged by two configuration bits, a rise bit and a fall bit. One bit set selects the edge that bit names. Neither bit set selects active-high level. Both bits set selects active-low level.

The lines form banks of 32. Each bank has a window of eight 32-bit registers, and the second bank's window starts 0x20 above the first. In edge modes a detected edge sets a sticky pending bit, and software clears it by writing ones. In level modes the pending bit follows the polarity-corrected input. Each configuration bit has its own set address and its own clear address, so software can change one line without a read-modify-write.

Top module: `irq_trigger_unit`

## Requirements
- R1: After reset the pending outputs and all configuration bits are zero, which means active-high level with nothing pending.
- R2: A change on an input line reaches `pending_o` on the third rising clock edge after it, and not earlier.
- R3: With rise=0 and fall=0 the pending bit of a line equals its synchronized input.
- R4: With rise=1 and fall=1 the pending bit of a line equals the inverse of its synchronized input.
- R5: With rise=1 and fall=0 a 0-to-1 transition sets the pending bit, and the bit stays set after the input returns low.
- R6: With rise=0 and fall=1 a 1-to-0 transition sets the pending bit, and a 0-to-1 transition does not.
- R7: In edge modes, writing a 1 to a bit of the raw status register (offset 0x04) clears that pending bit, and 0 bits leave the other bits unchanged.
- R8: When an edge is detected in the same cycle as a write-one clear of the same line, the pending bit stays set.
- R9: In level modes, writing ones to the raw status register has no effect on the pending bit.
- R10: Writing ones to 0x10 or 0x14 sets or clears rise bits. Writing ones to 0x18 or 0x1C sets or clears fall bits. 0 bits leave a bit unchanged. 0x08 and 0x0C read and write the rise and fall bits directly. Reads of a set or clear address return the configuration it acts on.
- R11: Lines 32 to 63 use a register window at 0x20 to 0x3C with the same layout, where bit n stands for line 32+n.
- R12: Reads of offsets 0x00 and 0x04 return the bank's pending bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Raw interrupt lines, asynchronous |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| pending_o | output | 64 | Conditioned pending signal per line |

## Verification
The hardest case to reach is the collision in R8. A new edge and a write-one clear must hit the pending register on the same clock edge. The edge first has to travel through the synchronizer and the previous-sample flop, so the stimulus must count cycles exactly. The bench first makes the line pending and lets the input settle low. It then raises the input on a falling clock edge, waits two rising edges, and issues the clear so that the clear is sampled on the third rising edge, together with the detected edge.

// File: rtl/irqt_pkg.sv
package irqt_pkg;

    // Register index inside a bank window (address bits [4:2])
    typedef enum logic [2:0] {
        SEL_STATUS   = 3'd0,
        SEL_RAW      = 3'd1,
        SEL_RISE     = 3'd2,
        SEL_FALL     = 3'd3,
        SEL_RISE_SET = 3'd4,
        SEL_RISE_CLR = 3'd5,
        SEL_FALL_SET = 3'd6,
        SEL_FALL_CLR = 3'd7
    } reg_sel_e;

    localparam int unsigned REG_IDX_LSB   = 2;
    localparam int unsigned BANK_ADDR_LSB = 5;

endpackage

// File: rtl/irqt_sync.sv
module irqt_sync #(
    parameter int unsigned WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);

    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
        logic [WIDTH-1:0] last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = async_i;
        st_d.stage2 = st_q.stage1;
        st_d.last   = st_q.stage2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_o  = st_q.stage2;
    assign prev_o = st_q.last;

endmodule

// File: rtl/irqt_bank.sv
module irqt_bank
    import irqt_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] prev_i,
    input  logic             we_i,
    input  reg_sel_e         sel_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic [WIDTH-1:0] pending_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    typedef struct packed {
        logic [WIDTH-1:0] rise;
        logic [WIDTH-1:0] fall;
        logic [WIDTH-1:0] raw;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic [WIDTH-1:0] level_mode;
    logic [WIDTH-1:0] level_val;
    logic [WIDTH-1:0] edge_hit;
    logic [WIDTH-1:0] ack_mask;

    always_comb begin
        st_d = st_q;

        // trigger evaluation uses the configuration held this cycle
        level_mode = ~(st_q.rise ^ st_q.fall);
        level_val  = cur_i ^ (st_q.rise & st_q.fall);
        edge_hit   = (cur_i & ~prev_i & st_q.rise & ~st_q.fall)
                   | (~cur_i & prev_i & st_q.fall & ~st_q.rise);
        ack_mask   = (we_i && sel_i == SEL_RAW) ? wdata_i : '0;

        st_d.raw = (level_mode & level_val)
                 | (~level_mode & (edge_hit | (st_q.raw & ~ack_mask)));

        if (we_i) begin
            unique case (sel_i)
                SEL_RISE:     st_d.rise = wdata_i;
                SEL_FALL:     st_d.fall = wdata_i;
                SEL_RISE_SET: st_d.rise = st_q.rise | wdata_i;
                SEL_RISE_CLR: st_d.rise = st_q.rise & ~wdata_i;
                SEL_FALL_SET: st_d.fall = st_q.fall | wdata_i;
                SEL_FALL_CLR: st_d.fall = st_q.fall & ~wdata_i;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (sel_i)
            SEL_STATUS, SEL_RAW:                  rdata_o = st_q.raw;
            SEL_RISE, SEL_RISE_SET, SEL_RISE_CLR: rdata_o = st_q.rise;
            default:                              rdata_o = st_q.fall;
        endcase
    end

    assign pending_o = st_q.raw;
    assign rise_o    = st_q.rise;
    assign fall_o    = st_q.fall;

endmodule

// File: rtl/irq_trigger_unit.sv
module irq_trigger_unit
    import irqt_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned BANK_W    = 32,
    localparam int unsigned NUM_LINES = NUM_BANKS * BANK_W,
    localparam int unsigned BSEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int unsigned ADDR_W    = BANK_ADDR_LSB + BSEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [BANK_W-1:0]    reg_wdata,
    output logic [BANK_W-1:0]    reg_rdata,
    output logic [NUM_LINES-1:0] pending_o
);

    logic [NUM_LINES-1:0] sync_cur;
    logic [NUM_LINES-1:0] sync_prev;
    logic [NUM_LINES-1:0] rise_all;
    logic [NUM_LINES-1:0] fall_all;
    logic [BANK_W-1:0]    bank_rdata [NUM_BANKS];
    logic [BSEL_W-1:0]    bank_sel;
    reg_sel_e             reg_sel;
    logic                 unused_addr_lsbs;

    assign bank_sel         = reg_addr[ADDR_W-1:BANK_ADDR_LSB];
    assign reg_sel          = reg_sel_e'(reg_addr[BANK_ADDR_LSB-1:REG_IDX_LSB]);
    assign unused_addr_lsbs = ^reg_addr[REG_IDX_LSB-1:0];

    irqt_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_in),
        .cur_o   (sync_cur),
        .prev_o  (sync_prev)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        irqt_bank #(.WIDTH(BANK_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .cur_i     (sync_cur[b*BANK_W +: BANK_W]),
            .prev_i    (sync_prev[b*BANK_W +: BANK_W]),
            .we_i      (reg_we && (int'(bank_sel) == b)),
            .sel_i     (reg_sel),
            .wdata_i   (reg_wdata),
            .rdata_o   (bank_rdata[b]),
            .pending_o (pending_o[b*BANK_W +: BANK_W]),
            .rise_o    (rise_all[b*BANK_W +: BANK_W]),
            .fall_o    (fall_all[b*BANK_W +: BANK_W])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(bank_sel) == b) begin
                reg_rdata = bank_rdata[b];
            end
        end
    end

endmodule

// File: rtl/irqt_checker.sv
module irqt_checker
    import irqt_pkg::*;
#(
    parameter int unsigned NL     = 64,
    parameter int unsigned BW     = 32,
    parameter int unsigned AW     = 6,
    parameter int unsigned BSW    = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input logic [BW-1:0] reg_wdata,
    input logic [NL-1:0] pending_o,
    input logic [NL-1:0] cur,
    input logic [NL-1:0] prev,
    input logic [NL-1:0] rise,
    input logic [NL-1:0] fall
);

    logic [NL-1:0] placed;
    logic [NL-1:0] ack_m;
    logic [NL-1:0] edge_ev;
    logic [NL-1:0] lvl_m;
    logic [NL-1:0] lvl_v;
    logic [2:0]    sel;
    logic          w_rset;
    logic          w_fset;
    logic          unused_lsbs;

    assign unused_lsbs = ^reg_addr[REG_IDX_LSB-1:0];
    assign sel    = reg_addr[BANK_ADDR_LSB-1:REG_IDX_LSB];
    assign placed = NL'(reg_wdata) << (int'(reg_addr[AW-1:BANK_ADDR_LSB]) * BW);
    assign ack_m  = (reg_we && sel == 3'(SEL_RAW)) ? placed : '0;
    assign w_rset = reg_we && sel == 3'(SEL_RISE_SET);
    assign w_fset = reg_we && sel == 3'(SEL_FALL_SET);
    assign lvl_m  = ~(rise ^ fall);
    assign lvl_v  = cur ^ (rise & fall);
    assign edge_ev = (cur & ~prev & rise & ~fall) | (~cur & prev & fall & ~rise);

    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pending_o ^ $past(lvl_v)) & $past(lvl_m)) == '0)); // R3

    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(edge_ev & ~lvl_m) & ~pending_o) == '0)); // R8

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pending_o & ~lvl_m & ~ack_m) & ~pending_o) == '0)); // R7

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(~pending_o & ~lvl_m & ~edge_ev) & pending_o) == '0)); // R5

    AST_RISE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        w_rset |=> (rise == $past(rise | placed))); // R10

    AST_FALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        w_fset |=> (fall == $past(fall | placed))); // R10

    AST_CFG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> ($stable(rise) && $stable(fall))); // R10

endmodule

bind irq_trigger_unit irqt_checker #(
    .NL  (NUM_LINES),
    .BW  (BANK_W),
    .AW  (ADDR_W),
    .BSW (BSEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pending_o (pending_o),
    .cur       (sync_cur),
    .prev      (sync_prev),
    .rise      (rise_all),
    .fall      (fall_all)
);

// File: tb/sim_irq_trigger_unit.sv
`timescale 1ns/1ps
module sim_irq_trigger_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] pending_o;

    int n_checks = 0;
    int n_err    = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    irq_trigger_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pending_o (pending_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 pending after reset", pending_o, 64'h0);
        rd(6'h08, d); check("R1 rise cfg bank0", {32'h0, d}, 64'h0);
        rd(6'h2C, d); check("R1 fall cfg bank1", {32'h0, d}, 64'h0);
    endtask

    task automatic t_latency();
        @(negedge clk); irq_in[3] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R2 not yet after two edges", {63'h0, pending_o[3]}, 64'h0);
        @(posedge clk); @(negedge clk);
        check("R3 level high follows on third edge", {63'h0, pending_o[3]}, 64'h1);
        irq_in[3] = 1'b0; settle();
        check("R3 level high drops", {63'h0, pending_o[3]}, 64'h0);
    endtask

    task automatic t_active_low();
        wr(6'h10, 32'h20);
        wr(6'h18, 32'h20);
        @(posedge clk); @(negedge clk);
        check("R4 active-low pending with input low", {63'h0, pending_o[5]}, 64'h1);
        irq_in[5] = 1'b1; settle();
        check("R4 active-low idle with input high", {63'h0, pending_o[5]}, 64'h0);
    endtask

    task automatic t_rise();
        wr(6'h10, 32'h80);
        irq_in[7] = 1'b1;
        @(negedge clk); @(negedge clk);
        irq_in[7] = 1'b0;
        repeat (5) @(negedge clk);
        check("R5 rising edge latched and held", {63'h0, pending_o[7]}, 64'h1);
        wr(6'h04, 32'h40);
        check("R7 zero bits leave pending", {63'h0, pending_o[7]}, 64'h1);
        wr(6'h04, 32'h80);
        check("R7 write-one clears edge pending", {63'h0, pending_o[7]}, 64'h0);
    endtask

    task automatic t_priority();
        irq_in[7] = 1'b1; settle();
        irq_in[7] = 1'b0; settle();
        check("R8 setup pending", {63'h0, pending_o[7]}, 64'h1);
        @(negedge clk); irq_in[7] = 1'b1;
        repeat (2) @(posedge clk);
        wr(6'h04, 32'h80);
        check("R8 edge beats same-cycle clear", {63'h0, pending_o[7]}, 64'h1);
        wr(6'h04, 32'h80);
        check("R8 later clear works", {63'h0, pending_o[7]}, 64'h0);
        irq_in[7] = 1'b0; settle();
    endtask

    task automatic t_fall_hi();
        logic [31:0] d;
        wr(6'h38, 32'h100);
        irq_in[40] = 1'b1; settle();
        check("R6 rising ignored in falling mode", {63'h0, pending_o[40]}, 64'h0);
        irq_in[40] = 1'b0; settle();
        check("R6 falling edge latched line 40", {63'h0, pending_o[40]}, 64'h1);
        rd(6'h20, d); check("R11 R12 bank1 status read", {32'h0, d}, 64'h100);
        rd(6'h24, d); check("R12 bank1 raw read", {32'h0, d}, 64'h100);
        rd(6'h00, d); check("R11 bank0 status separate", {32'h0, d & 32'h100}, 64'h0);
        wr(6'h24, 32'h100);
        check("R11 bank1 clear", {63'h0, pending_o[40]}, 64'h0);
    endtask

    task automatic t_level_ack();
        irq_in[3] = 1'b1; settle();
        wr(6'h04, 32'h8);
        check("R9 level write-one no effect", {63'h0, pending_o[3]}, 64'h1);
        repeat (2) @(negedge clk);
        check("R9 level still pending", {63'h0, pending_o[3]}, 64'h1);
        irq_in[3] = 1'b0; settle();
    endtask

    task automatic t_cfg();
        logic [31:0] d;
        rd(6'h08, d); check("R10 rise cfg read", {32'h0, d}, 64'hA0);
        wr(6'h10, 32'h0);
        rd(6'h08, d); check("R10 zero set leaves cfg", {32'h0, d}, 64'hA0);
        rd(6'h10, d); check("R10 set addr reads cfg", {32'h0, d}, 64'hA0);
        wr(6'h14, 32'h80);
        rd(6'h14, d); check("R10 clear removes bit", {32'h0, d}, 64'h20);
        rd(6'h0C, d); check("R10 fall cfg read", {32'h0, d}, 64'h20);
        wr(6'h1C, 32'h20);
        rd(6'h18, d); check("R10 fall clear", {32'h0, d}, 64'h0);
        wr(6'h0C, 32'h3);
        rd(6'h1C, d); check("R10 direct fall write", {32'h0, d}, 64'h3);
        rd(6'h2C, d); check("R11 bank1 fall cfg", {32'h0, d}, 64'h100);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_latency();
        t_active_low();
        t_rise();
        t_priority();
        t_fall_hi();
        t_level_ack();
        t_cfg();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule